// File: doc/BRIEF.md
# CDR Lock and Signal-Loss Supervisor

This block supervises one receive channel of a clock-and-data-recovery front end. It runs entirely on the local reference clock. It decides whether the recovery loop is trained on the reference or follows the incoming line data, and when recovered data must be muted. The recovered clock arrives as a slow toggle, divided down by `TGL_DIV`. The block synchronizes that toggle and counts its rising edges over a fixed window of 2^`WIN_LOG2` reference cycles. At the end of each window it compares the count with a value computed for the selected line rate and reference frequency.

After reset the loop is held on the reference for `REF_SETTLE` cycles. It then waits for clean measurement windows before it hands the loop to the data. Loss of signal can come from the optical module's signal-detect pin, whose polarity is configurable, or from an internal digital flag. Loss of signal mutes the data and forces the loop back to the reference. A frequency error does the same but leaves the data unmuted. Every loss of lock sets a sticky flag, which raises an interrupt request when enabled.

Top module: `cdr_lock_sup`

## Requirements
- R1: After reset `lol` and `train_ref` are 1 and `lol_sticky` and `irq` are 0. `lol` stays 1 for at least the first `REF_SETTLE` cycles.
- R2: The block counts rising edges of `rec_tgl` over each window of 2^`WIN_LOG2` reference cycles. The lock state is updated only from the window-end decision.
- R3: The expected count is round(2^WIN_LOG2 * L / (F * TGL_DIV)). The allowed difference is floor(expected/2048)+1, which is about 500 ppm.
- R4: L comes from `rate_sel`: 00 gives 96 (622.08 Mb/s), 01 gives 24 (155.52 Mb/s), and 10 or 11 give 8 (51.84 Mb/s). F comes from `ref_hi`: 1 gives 12 (77.76 MHz) and 0 gives 3 (19.44 MHz).
- R5: Loss of signal is `dlos` high or signal-detect absent. `mute` follows loss of signal with exactly two reference-clock stages of delay.
- R6: Loss of signal while tracking returns the loop to the reference: `lol` and `train_ref` go to 1 one cycle after `mute` rises.
- R7: An out-of-tolerance window while tracking sets `lol` and `train_ref` after that window's decision. It does not set `mute`.
- R8: The loop moves to the data (`lol`=0, `train_ref`=0) only after two consecutive in-tolerance windows. Loss of signal must be absent for the whole of each of those windows.
- R9: With `sd_act_low`=0, `sd_pin`=1 means signal present. With `sd_act_low`=1, `sd_pin`=0 means signal present.
- R10: `lol_sticky` is set by every transition from tracking to the reference. It is cleared by a one-cycle `lol_clr` pulse, and a set in the same cycle wins over the clear.
- R11: `irq` equals `lol_sticky` when `irq_en` is 1 and is 0 when `irq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_tgl | input | 1 | Divided recovered-clock toggle, asynchronous |
| sd_pin | input | 1 | Signal-detect from the optical module, asynchronous |
| sd_act_low | input | 1 | 1: signal-detect is active low |
| dlos | input | 1 | Internal digital loss-of-signal flag, asynchronous |
| rate_sel | input | 2 | Line-rate code |
| ref_hi | input | 1 | 1: 77.76 MHz reference, 0: 19.44 MHz |
| irq_en | input | 1 | Interrupt enable for the sticky flag |
| lol_clr | input | 1 | Write-one-to-clear pulse for the sticky flag |
| lol | output | 1 | Loss of lock (loop not tracking data) |
| train_ref | output | 1 | 1: loop trained on reference, 0: on data |
| mute | output | 1 | Force recovered data to zero |
| lol_sticky | output | 1 | Latched loss-of-lock event |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same clock edge: a new lock-loss event that sets the sticky flag, and a software clear of that flag. The bench provokes this collision by removing signal-detect at a known negedge and counting the two synchronizer stages. It then holds `lol_clr` high across exactly the edge at which the state machine sees loss of signal. The check is that `lol_sticky` reads 1 after that edge and that a later lone clear pulse drops it. The bench also aligns a frequency step and a loss-of-signal burst to known window boundaries. This shows that a window stained by loss of signal does not count toward the two-window acquisition.

// File: rtl/cdr_sup_pkg.sv
// Package: shared state encoding and the constant arithmetic for the
// expected edge count and its tolerance. Assumes the toggle divider and the
// window are chosen so that the count stays below half the window.
package cdr_sup_pkg;

    typedef enum logic [1:0] {
        ST_REF_TRAIN = 2'd0,
        ST_REF_HOLD  = 2'd1,
        ST_TRACK     = 2'd2
    } lock_st_t;

    // Index bits: [2] reference-high select, [1:0] rate code.
    // Rates and references are in units of 6.48 MHz.
    function automatic int expected_count(int win_log2, int tgl_div, int idx);
        longint line_u;
        longint ref_u;
        longint num;
        longint den;
        case (idx & 3)
            0:       line_u = 96;
            1:       line_u = 24;
            default: line_u = 8;
        endcase
        ref_u = (((idx >> 2) & 1) == 1) ? 64'sd12 : 64'sd3;
        num   = (64'sd1 <<< win_log2) * line_u;
        den   = ref_u * longint'(tgl_div);
        return int'((num + den / 2) / den);
    endfunction

    // Roughly 500 ppm of the expected count plus one count of phase slip.
    function automatic int tolerance_count(int expected);
        return (expected >>> 11) + 1;
    endfunction

endpackage

// File: rtl/cdr_sync.sv
// Module: multi-stage synchronizer for one asynchronous level into the
// reference domain. Assumes STAGES >= 2; RST_VAL is the value presented
// while in reset.
module cdr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {STAGES{RST_VAL}};
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/cdr_rate_meter.sv
// Module: counts rising edges of the synchronized recovered-clock toggle over
// a window of 2^WIN_LOG2 reference cycles and flags whether the count lies
// within tolerance of the value for the selected rate and reference.
// Assumes the toggle's period is at least two reference cycles.
module cdr_rate_meter
    import cdr_sup_pkg::*;
#(
    parameter int WIN_LOG2    = 16,
    parameter int TGL_DIV     = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tgl_async,
    input  logic [1:0] rate_sel,
    input  logic       ref_hi,
    output logic       win_end,
    output logic       win_ok
);
    localparam int CNT_W = WIN_LOG2 + 1;
    localparam int N_SEL = 8;

    logic             tgl_s;
    logic             tgl_d;
    logic             rise;
    logic [WIN_LOG2-1:0] win_cnt;
    logic             win_last;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] exp_tab [N_SEL];
    logic [CNT_W-1:0] tol_tab [N_SEL];
    logic [CNT_W-1:0] exp_cur;
    logic [CNT_W-1:0] tol_cur;
    logic [CNT_W-1:0] diff;
    logic [2:0]       sel;

    cdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tgl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tgl_async),
        .q     (tgl_s)
    );

    // Constant tables of expected counts and tolerances, one per selection.
    for (genvar g = 0; g < N_SEL; g++) begin : g_tab
        assign exp_tab[g] = CNT_W'(expected_count(WIN_LOG2, TGL_DIV, g));
        assign tol_tab[g] = CNT_W'(tolerance_count(expected_count(WIN_LOG2, TGL_DIV, g)));
    end

    assign sel      = {ref_hi, rate_sel};
    assign exp_cur  = exp_tab[sel];
    assign tol_cur  = tol_tab[sel];
    assign rise     = tgl_s & ~tgl_d;
    assign win_last = &win_cnt;
    assign total    = edge_cnt + CNT_W'(rise);
    assign diff     = (total >= exp_cur) ? (total - exp_cur) : (exp_cur - total);

    // Delay the synchronized toggle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_d <= 1'b0;
        else        tgl_d <= tgl_s;
    end

    // Free-running window position.
    always_ff @(posedge clk) begin
        if (!rst_n) win_cnt <= '0;
        else        win_cnt <= win_cnt + 1'b1;
    end

    // Accumulate edges and issue the window decision one cycle after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            win_end  <= 1'b0;
            win_ok   <= 1'b0;
        end else if (win_last) begin
            edge_cnt <= '0;
            win_end  <= 1'b1;
            win_ok   <= (diff <= tol_cur);
        end else begin
            edge_cnt <= total;
            win_end  <= 1'b0;
        end
    end
endmodule

// File: rtl/cdr_los_qual.sv
// Module: brings signal-detect and the digital loss flag into the reference
// domain and forms the loss-of-signal level. Assumes the polarity select is
// static. In reset the loss flag is presented as asserted so data is muted.
module cdr_los_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sd_pin,
    input  logic sd_act_low,
    input  logic dlos,
    output logic los
);
    logic sd_s;
    logic dlos_s;
    logic sd_present;

    cdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sd_pin),
        .q     (sd_s)
    );

    cdr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dlos_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dlos),
        .q     (dlos_s)
    );

    // Apply the polarity select and merge both loss sources.
    always_comb begin
        sd_present = sd_s ^ sd_act_low;
        los        = dlos_s | ~sd_present;
    end
endmodule

// File: rtl/cdr_lock_fsm.sv
// Module: lock state machine. It settles on the reference after reset, then
// needs ACQ_WINDOWS consecutive clean in-tolerance windows before it tracks
// data. It drops back on loss of signal or a bad window, and keeps a sticky
// loss-of-lock flag with an interrupt. Assumes win_end is a one-cycle pulse.
module cdr_lock_fsm
    import cdr_sup_pkg::*;
#(
    parameter int REF_SETTLE  = 4096,
    parameter int ACQ_WINDOWS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic los,
    input  logic win_end,
    input  logic win_ok,
    input  logic lol_clr,
    input  logic irq_en,
    output logic lol,
    output logic train_ref,
    output logic lol_sticky,
    output logic irq
);
    localparam int SET_W = $clog2(REF_SETTLE + 1);
    localparam int RUN_W = $clog2(ACQ_WINDOWS + 1);

    lock_st_t         st;
    logic [SET_W-1:0] settle_cnt;
    logic [RUN_W-1:0] good_run;
    logic             los_seen;
    logic             good_win;
    logic             lose_evt;

    assign good_win = win_end & win_ok & ~los_seen & ~los;
    assign lose_evt = (st == ST_TRACK) & (los | (win_end & ~win_ok));

    // Remember any loss of signal within the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)       los_seen <= 1'b1;
        else if (win_end) los_seen <= los;
        else              los_seen <= los_seen | los;
    end

    // Advance the lock state and the acquisition run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_REF_TRAIN;
            settle_cnt <= '0;
            good_run   <= '0;
        end else begin
            case (st)
                ST_REF_TRAIN: begin
                    settle_cnt <= settle_cnt + 1'b1;
                    if (settle_cnt == SET_W'(REF_SETTLE - 1)) st <= ST_REF_HOLD;
                end
                ST_REF_HOLD: begin
                    if (los) begin
                        good_run <= '0;
                    end else if (win_end) begin
                        if (good_win) begin
                            if (good_run == RUN_W'(ACQ_WINDOWS - 1)) begin
                                st       <= ST_TRACK;
                                good_run <= '0;
                            end else begin
                                good_run <= good_run + 1'b1;
                            end
                        end else begin
                            good_run <= '0;
                        end
                    end
                end
                ST_TRACK: begin
                    if (lose_evt) st <= ST_REF_HOLD;
                end
                default: st <= ST_REF_TRAIN;
            endcase
        end
    end

    // Sticky loss-of-lock flag; a new event takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        lol_sticky <= 1'b0;
        else if (lose_evt) lol_sticky <= 1'b1;
        else if (lol_clr)  lol_sticky <= 1'b0;
    end

    // Status outputs derived from the state.
    always_comb begin
        lol       = (st != ST_TRACK);
        train_ref = lol;
        irq       = lol_sticky & irq_en;
    end
endmodule

// File: rtl/cdr_lock_sup.sv
// Module: top of the per-channel lock and signal-loss supervisor. It ties the
// rate meter, the loss-of-signal qualifier and the lock state machine
// together. All logic runs on the local reference clock.
module cdr_lock_sup #(
    parameter int WIN_LOG2    = 16,
    parameter int TGL_DIV     = 128,
    parameter int REF_SETTLE  = 4096,
    parameter int ACQ_WINDOWS = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rec_tgl,
    input  logic       sd_pin,
    input  logic       sd_act_low,
    input  logic       dlos,
    input  logic [1:0] rate_sel,
    input  logic       ref_hi,
    input  logic       irq_en,
    input  logic       lol_clr,
    output logic       lol,
    output logic       train_ref,
    output logic       mute,
    output logic       lol_sticky,
    output logic       irq
);
    logic win_end;
    logic win_ok;
    logic los;

    cdr_rate_meter #(
        .WIN_LOG2    (WIN_LOG2),
        .TGL_DIV     (TGL_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgl_async (rec_tgl),
        .rate_sel  (rate_sel),
        .ref_hi    (ref_hi),
        .win_end   (win_end),
        .win_ok    (win_ok)
    );

    cdr_los_qual #(.SYNC_STAGES(SYNC_STAGES)) u_los (
        .clk        (clk),
        .rst_n      (rst_n),
        .sd_pin     (sd_pin),
        .sd_act_low (sd_act_low),
        .dlos       (dlos),
        .los        (los)
    );

    cdr_lock_fsm #(
        .REF_SETTLE  (REF_SETTLE),
        .ACQ_WINDOWS (ACQ_WINDOWS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .los        (los),
        .win_end    (win_end),
        .win_ok     (win_ok),
        .lol_clr    (lol_clr),
        .irq_en     (irq_en),
        .lol        (lol),
        .train_ref  (train_ref),
        .lol_sticky (lol_sticky),
        .irq        (irq)
    );

    assign mute = los;
endmodule

// File: rtl/cdr_lock_sup_chk.sv
// Module: assertion checker attached to the supervisor top by bind. Assumes
// it sees the top's ports plus the meter's window decision.
module cdr_lock_sup_chk #(
    parameter int REF_SETTLE = 4096
) (
    input logic clk,
    input logic rst_n,
    input logic lol,
    input logic train_ref,
    input logic mute,
    input logic lol_sticky,
    input logic irq,
    input logic irq_en,
    input logic lol_clr,
    input logic win_end,
    input logic win_ok
);
    logic [31:0] since_rst;

    // Saturating count of cycles since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)                    since_rst <= '0;
        else if (since_rst < REF_SETTLE) since_rst <= since_rst + 1;
    end

    a_r1_ref_first: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < REF_SETTLE) |-> lol);

    a_r6_mute_forces_ref: assert property (@(posedge clk) disable iff (!rst_n)
        mute |=> train_ref);

    a_r7_bad_window_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!lol && win_end && !win_ok) |=> lol);

    a_r8_lock_at_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lol) |-> $past(win_end));

    a_r10_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol) |-> lol_sticky);

    a_r10_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lol_clr) && !$rose(lol)) |-> !lol_sticky);

    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind cdr_lock_sup cdr_lock_sup_chk #(.REF_SETTLE(REF_SETTLE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lol        (lol),
    .train_ref  (train_ref),
    .mute       (mute),
    .lol_sticky (lol_sticky),
    .irq        (irq),
    .irq_en     (irq_en),
    .lol_clr    (lol_clr),
    .win_end    (win_end),
    .win_ok     (win_ok)
);

// File: tb/cdr_lock_sup_test.sv
module cdr_lock_sup_test;
    localparam int WL  = 10;
    localparam int WIN = 1 << WL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rec_tgl = 1'b0;
    logic       sd_pin = 1'b0;
    logic       sd_act_low = 1'b0;
    logic       dlos = 1'b1;
    logic [1:0] rate_sel = 2'b00;
    logic       ref_hi = 1'b1;
    logic       irq_en = 1'b0;
    logic       lol_clr = 1'b0;
    logic       lol, train_ref, mute, lol_sticky, irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int hp = 8;

    cdr_lock_sup #(
        .WIN_LOG2 (WL), .TGL_DIV (128), .REF_SETTLE (64),
        .ACQ_WINDOWS (2), .SYNC_STAGES (2)
    ) uut (
        .clk (clk), .rst_n (rst_n), .rec_tgl (rec_tgl), .sd_pin (sd_pin),
        .sd_act_low (sd_act_low), .dlos (dlos), .rate_sel (rate_sel),
        .ref_hi (ref_hi), .irq_en (irq_en), .lol_clr (lol_clr),
        .lol (lol), .train_ref (train_ref), .mute (mute),
        .lol_sticky (lol_sticky), .irq (irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Recovered-clock toggle: half period of hp reference cycles.
    initial begin
        forever begin
            repeat (hp) @(negedge clk);
            rec_tgl = ~rec_tgl;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset(input logic sd, input logic pol, input logic dl,
                            input logic [1:0] rs, input logic rh, input int h);
        @(negedge clk);
        rst_n = 1'b0; sd_pin = sd; sd_act_low = pol; dlos = dl;
        rate_sel = rs; ref_hi = rh; hp = h; lol_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1, R5: reset state and unmute after the two sync stages.
    task automatic t_reset;
        irq_en = 1'b1;
        do_reset(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 8);
        chk("R1 lol after reset", lol, 1'b1);
        chk("R1 train_ref after reset", train_ref, 1'b1);
        chk("R1 sticky after reset", lol_sticky, 1'b0);
        chk("R1 irq after reset", irq, 1'b0);
        wait_cyc(4);
        chk("R5 mute clears with signal present", mute, 1'b0);
        wait_cyc(40);
        chk("R1 still on reference while settling", train_ref, 1'b1);
    endtask

    // R2, R8: two clean windows needed (window 1 stained by reset LOS).
    task automatic t_acquire;
        irq_en = 1'b1;
        do_reset(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 8);
        wait_cyc(2 * WIN + 8);
        chk("R8 one clean window is not enough", lol, 1'b1);
        wait_cyc(3 * WIN + 8);
        chk("R8 locked after two clean windows", lol, 1'b0);
        chk("R8 train_ref released", train_ref, 1'b0);
        chk("R2 no sticky on first lock", lol_sticky, 1'b0);
    endtask

    // R7, R10, R11: frequency step drops lock without muting.
    task automatic t_freq_step;
        irq_en = 1'b1;
        do_reset(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 8);
        wait_cyc(3 * WIN + 8);
        chk("R7 locked before step", lol, 1'b0);
        hp = 9;
        wait_cyc(4 * WIN - 8);
        chk("R2 decision waits for window end", lol, 1'b0);
        wait_cyc(4 * WIN + 8);
        chk("R7 lol after bad window", lol, 1'b1);
        chk("R7 back on reference", train_ref, 1'b1);
        chk("R7 no mute on frequency error", mute, 1'b0);
        chk("R10 sticky set", lol_sticky, 1'b1);
        chk("R11 irq follows sticky", irq, 1'b1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R11 irq gated off", irq, 1'b0);
        hp = 8;
        wait_cyc(7 * WIN + 8);
        chk("R8 relock after frequency restored", lol, 1'b0);
        chk("R10 sticky holds after relock", lol_sticky, 1'b1);
    endtask

    // R5, R6, R10: signal-detect loss collides with a clear pulse.
    task automatic t_los_clear_collision;
        irq_en = 1'b1;
        do_reset(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 8);
        wait_cyc(3 * WIN + 8);
        chk("R6 locked before loss", lol, 1'b0);
        sd_pin = 1'b0;
        @(negedge clk);
        chk("R5 mute not yet after one stage", mute, 1'b0);
        @(negedge clk);
        chk("R5 mute after two stages", mute, 1'b1);
        chk("R6 lol not yet", lol, 1'b0);
        lol_clr = 1'b1;
        @(negedge clk);
        lol_clr = 1'b0;
        chk("R6 lol one cycle after mute", lol, 1'b1);
        chk("R10 set wins over clear", lol_sticky, 1'b1);
        lol_clr = 1'b1;
        @(negedge clk);
        lol_clr = 1'b0;
        chk("R10 clear pulse alone", lol_sticky, 1'b0);
        chk("R11 irq drops with sticky", irq, 1'b0);
        @(negedge clk);
        sd_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 mute released", mute, 1'b0);
    endtask

    // R5, R8: digital LOS burst stains a whole window.
    task automatic t_dlos_window;
        do_reset(1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 8);
        wait_cyc(3 * WIN + 8);
        wait_cyc(3 * WIN + 30);
        dlos = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 mute on digital LOS", mute, 1'b1);
        chk("R6 lol on digital LOS", lol, 1'b1);
        wait_cyc(3 * WIN + 130);
        dlos = 1'b0;
        wait_cyc(5 * WIN + 8);
        chk("R8 stained window not counted", lol, 1'b1);
        wait_cyc(6 * WIN + 8);
        chk("R8 relock after two clean windows", lol, 1'b0);
    endtask

    // R9: active-low signal-detect.
    task automatic t_polarity;
        do_reset(1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 8);
        wait_cyc(6);
        chk("R9 low pin means present", mute, 1'b0);
        wait_cyc(3 * WIN + 8);
        chk("R9 locks with active-low detect", lol, 1'b0);
        sd_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 high pin means absent", mute, 1'b1);
    endtask

    // R3, R4: expected count scaled by rate code and reference.
    task automatic t_rates;
        do_reset(1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 24);
        wait_cyc(3 * WIN + 8);
        chk("R4 51.84 on 19.44 ref locks", lol, 1'b0);
        do_reset(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 32);
        wait_cyc(3 * WIN + 8);
        chk("R4 155.52 on 77.76 ref locks", lol, 1'b0);
        do_reset(1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 96);
        wait_cyc(3 * WIN + 8);
        chk("R4 code 11 treated as 51.84", lol, 1'b0);
        do_reset(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 8);
        wait_cyc(3 * WIN + 8);
        chk("R3 wrong reference never locks", lol, 1'b1);
        do_reset(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 8);
        wait_cyc(3 * WIN + 8);
        chk("R3 wrong rate never locks", lol, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_acquire();
        t_freq_step();
        t_los_clear_collision();
        t_dlos_window();
        t_polarity();
        t_rates();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule